// File: doc/BRIEF.md
# Programmable Event Router

The router gathers a wide bank of event inputs, organised as `NUM_GROUPS` groups of `GROUP_W` bits, and turns them into `NUM_OUTS` output request lines. Every input first passes through a two-flop synchroniser, so asynchronous sources may be connected directly. Per input, software chooses level or edge sensitivity and the active polarity. Edge-sensitive inputs capture detected edges in a sticky latch. Software can force this latch on to inject an event, or clear it once the event has been served.

A raw status bit shows whether each input is currently active. A global enable mask turns that into a pending bit. The mask can be written directly, or changed bit by bit through write-one-to-set and write-one-to-clear aliases, so concurrent agents never need a read-modify-write sequence. Each output has its own per-input selection mask. The output is high while any selected input is pending.

All configuration and status is reached through a simple word-wide register port. A read returns its data one clock after it is requested.

Top module: `event_router`

## Requirements
- R1: An input with sensitivity bit 0 (level) is active while its synchronised value equals its polarity bit: polarity 1 means high-active and 0 means low-active. Its raw status follows a pin change two clocks later.
- R2: An input with sensitivity bit 1 (edge) sets its latch on a rising edge when polarity is 1, or on a falling edge when polarity is 0. The raw status rises three clocks after the pin change and stays set after the pin returns. Latches of level inputs stay empty.
- R3: Writing ones to the edge-clear alias empties the latches of those edge inputs. Zero bits leave the latches unchanged.
- R4: Writing ones to the edge-set alias fills the latches of those edge inputs and has no effect on level inputs. When a latch receives a set or a detected edge in the same cycle as a clear, it ends up set.
- R5: The global mask can be written directly. Writing ones to the mask-set alias sets those bits, and writing ones to the mask-clear alias clears them. Zero bits in either alias change nothing.
- R6: A pending bit is the raw status bit ANDed with the global mask bit. Writes to the pending address change nothing.
- R7: After reset, polarity is all ones, sensitivity is all zeros, the global mask is all ones, the output masks and latches are zero, and all outputs are low.
- R8: Output k is the OR over all inputs of (pending AND output-mask k). It follows the register state with no extra clock.
- R9: The address is {select[3:0], group}. The select codes are 0 polarity, 1 sensitivity, 2 edge-clear, 3 edge-set, 4 raw (read-only), 5 mask, 6 mask-clear, 7 mask-set, 8 pending (read-only), and 9+k output mask k. Read data appears one clock after the read strobe. Reads of write-only or unmapped codes return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_pin_i | input | NUM_GROUPS*GROUP_W | Event inputs, may be asynchronous |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 4+clog2(NUM_GROUPS) | Register address {select, group} |
| bus_wdata_i | input | GROUP_W | Write data |
| bus_rdata_o | output | GROUP_W | Read data, valid the clock after a read strobe |
| evt_o | output | NUM_OUTS | Routed event outputs |

## Verification
Results fall due at different latencies. A level input appears in raw status two clocks after its pin changes, and an edge appears three clocks after. A register write takes effect at the next edge, and read data arrives one clock after the strobe. The outputs are combinational from registered state. The bench's reference model advances one step per rising edge with the same pipeline latencies and compares the outputs and any pending read at the falling edge that follows. The same-cycle collision between an edge and a clear is staged by driving the clear exactly at the edge where the detection registers.

// File: rtl/er_pkg.sv
package er_pkg;
    localparam int SEL_W = 4;

    typedef enum logic [SEL_W-1:0] {
        SEL_POL    = 4'd0,
        SEL_KIND   = 4'd1,
        SEL_ECLR   = 4'd2,
        SEL_ESET   = 4'd3,
        SEL_RAW    = 4'd4,
        SEL_MASK   = 4'd5,
        SEL_MCLR   = 4'd6,
        SEL_MSET   = 4'd7,
        SEL_PEND   = 4'd8,
        SEL_OMASK0 = 4'd9
    } sel_e;
endpackage

// File: rtl/er_sync.sv
module er_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] lvl_o,
    output logic [W-1:0] prev_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
        logic [W-1:0] prev;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d.s1   = pin_i;
        st_d.s2   = st_q.s1;
        st_d.prev = st_q.s2;
        lvl_o     = st_q.s2;
        prev_o    = st_q.prev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/er_edge_bank.sv
module er_edge_bank #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sync_i,
    input  logic [W-1:0] prev_i,
    input  logic [W-1:0] pol_i,
    input  logic [W-1:0] kind_i,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] raw_o
);
    typedef struct packed {
        logic [W-1:0] lat;
    } st_t;

    st_t          st_d, st_q;
    logic [W-1:0] det;

    always_comb begin
        det      = kind_i & ((pol_i & sync_i & ~prev_i) | (~pol_i & ~sync_i & prev_i));
        // a capture (edge or forced set) outranks a clear in the same cycle
        st_d.lat = kind_i & ((st_q.lat & ~clr_i) | det | set_i);
        raw_o    = (kind_i & st_q.lat) | (~kind_i & ~(sync_i ^ pol_i));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|(set_i & kind_i)) |=> ((st_q.lat & $past(set_i & kind_i)) == $past(set_i & kind_i)));

    a_r2_edge_held: assert property (@(posedge clk) disable iff (!rst_n)
        (|det) |=> ((st_q.lat & $past(det)) == $past(det)));

    a_r3_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_i & kind_i & ~set_i & ~det)) |=>
        ((st_q.lat & $past(clr_i & kind_i & ~set_i & ~det)) == '0));

    a_r2_level_empty: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st_q.lat & ~$past(kind_i)) == '0));
endmodule

// File: rtl/er_out_merge.sv
module er_out_merge #(
    parameter int W  = 128,
    parameter int NO = 5
) (
    input  logic [W-1:0]          pend_i,
    input  logic [NO-1:0][W-1:0]  omask_i,
    output logic [NO-1:0]         evt_o
);
    for (genvar k = 0; k < NO; k++) begin : g_out
        assign evt_o[k] = |(pend_i & omask_i[k]);
    end
endmodule

// File: rtl/event_router.sv
module event_router #(
    parameter int NUM_GROUPS = 4,
    parameter int GROUP_W    = 32,
    parameter int NUM_OUTS   = 5
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic [NUM_GROUPS*GROUP_W-1:0]             evt_pin_i,
    input  logic                                      bus_wr_i,
    input  logic                                      bus_rd_i,
    input  logic [er_pkg::SEL_W+$clog2(NUM_GROUPS)-1:0] bus_addr_i,
    input  logic [GROUP_W-1:0]                        bus_wdata_i,
    output logic [GROUP_W-1:0]                        bus_rdata_o,
    output logic [NUM_OUTS-1:0]                       evt_o
);
    import er_pkg::*;

    localparam int N    = NUM_GROUPS * GROUP_W;
    localparam int GS_W = $clog2(NUM_GROUPS);

    typedef struct packed {
        logic [N-1:0]                pol;
        logic [N-1:0]                kind;
        logic [N-1:0]                mask;
        logic [NUM_OUTS-1:0][N-1:0]  omask;
        logic [GROUP_W-1:0]          rdata;
    } st_t;

    st_t            st_d, st_q;
    logic [N-1:0]   lvl, prev, raw, pend;
    logic [N-1:0]   eset_v, eclr_v, mset_v, mclr_v;
    logic [SEL_W-1:0] sel;
    logic [GS_W-1:0]  grp;
    logic             grp_ok;
    int               oi;

    assign sel    = bus_addr_i[GS_W +: SEL_W];
    assign grp    = bus_addr_i[GS_W-1:0];
    assign grp_ok = (int'(grp) < NUM_GROUPS);

    er_sync #(.W(N)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_i(evt_pin_i), .lvl_o(lvl), .prev_o(prev)
    );

    er_edge_bank #(.W(N)) u_edge (
        .clk(clk), .rst_n(rst_n), .sync_i(lvl), .prev_i(prev),
        .pol_i(st_q.pol), .kind_i(st_q.kind), .set_i(eset_v), .clr_i(eclr_v),
        .raw_o(raw)
    );

    assign pend = raw & st_q.mask;

    er_out_merge #(.W(N), .NO(NUM_OUTS)) u_merge (
        .pend_i(pend), .omask_i(st_q.omask), .evt_o(evt_o)
    );

    always_comb begin
        st_d   = st_q;
        eset_v = '0;
        eclr_v = '0;
        mset_v = '0;
        mclr_v = '0;
        oi     = int'(sel) - int'(SEL_OMASK0);

        if (bus_wr_i && grp_ok) begin
            case (sel)
                SEL_POL:  st_d.pol[grp*GROUP_W +: GROUP_W]  = bus_wdata_i;
                SEL_KIND: st_d.kind[grp*GROUP_W +: GROUP_W] = bus_wdata_i;
                SEL_ECLR: eclr_v[grp*GROUP_W +: GROUP_W]    = bus_wdata_i;
                SEL_ESET: eset_v[grp*GROUP_W +: GROUP_W]    = bus_wdata_i;
                SEL_MASK: st_d.mask[grp*GROUP_W +: GROUP_W] = bus_wdata_i;
                SEL_MCLR: mclr_v[grp*GROUP_W +: GROUP_W]    = bus_wdata_i;
                SEL_MSET: mset_v[grp*GROUP_W +: GROUP_W]    = bus_wdata_i;
                default: begin
                    if (oi >= 0 && oi < NUM_OUTS)
                        st_d.omask[oi][grp*GROUP_W +: GROUP_W] = bus_wdata_i;
                end
            endcase
        end
        st_d.mask = (st_d.mask & ~mclr_v) | mset_v;

        st_d.rdata = '0;
        if (bus_rd_i && grp_ok) begin
            case (sel)
                SEL_POL:  st_d.rdata = st_q.pol[grp*GROUP_W +: GROUP_W];
                SEL_KIND: st_d.rdata = st_q.kind[grp*GROUP_W +: GROUP_W];
                SEL_RAW:  st_d.rdata = raw[grp*GROUP_W +: GROUP_W];
                SEL_MASK: st_d.rdata = st_q.mask[grp*GROUP_W +: GROUP_W];
                SEL_PEND: st_d.rdata = pend[grp*GROUP_W +: GROUP_W];
                default: begin
                    if (oi >= 0 && oi < NUM_OUTS)
                        st_d.rdata = st_q.omask[oi][grp*GROUP_W +: GROUP_W];
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pol   <= '1;
            st_q.kind  <= '0;
            st_q.mask  <= '1;
            st_q.omask <= '0;
            st_q.rdata <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata_o = st_q.rdata;

    a_r5_mask_set: assert property (@(posedge clk) disable iff (!rst_n)
        (|mset_v) |=> ((st_q.mask & $past(mset_v)) == $past(mset_v)));

    a_r5_mask_clr: assert property (@(posedge clk) disable iff (!rst_n)
        (|mclr_v) |=> ((st_q.mask & $past(mclr_v)) == '0));

    a_r8_quiet_when_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mask == '0) |-> (evt_o == '0));

    a_r6_pend_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_i && sel == SEL_PEND) |=> ($stable(st_q.mask) && $stable(st_q.pol) && $stable(st_q.kind)));
endmodule

// File: tb/sim_event_router.sv
module sim_event_router;
    localparam int NG = 4;
    localparam int GW = 32;
    localparam int NO = 5;
    localparam int N  = NG * GW;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [N-1:0]      pins = '0;
    logic              wr = 1'b0, rd = 1'b0;
    logic [5:0]        addr = '0;
    logic [GW-1:0]     wdata = '0;
    logic [GW-1:0]     rdata;
    logic [NO-1:0]     evt;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    event_router #(.NUM_GROUPS(NG), .GROUP_W(GW), .NUM_OUTS(NO)) u0 (
        .clk(clk), .rst_n(rst_n), .evt_pin_i(pins), .bus_wr_i(wr), .bus_rd_i(rd),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .evt_o(evt)
    );

    // reference model state
    logic [N-1:0]  m_s1, m_s2, m_prev, m_lat, m_pol, m_kind, m_mask;
    logic [N-1:0]  m_om [NO];
    logic [N-1:0]  m_raw, m_det, m_set, m_clr, m_mset, m_mclr;
    logic [GW-1:0] m_rd;
    logic          m_rd_due = 1'b0;

    function automatic logic [N-1:0] raw_of(input logic [N-1:0] k, l, s, p);
        return (k & l) | (~k & ~(s ^ p));
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 = '0; m_s2 = '0; m_prev = '0; m_lat = '0;
            m_pol = '1; m_kind = '0; m_mask = '1;
            for (int k = 0; k < NO; k++) m_om[k] = '0;
            m_rd_due = 1'b0;
        end else begin
            int s, g;
            s = int'(addr[5:2]);
            g = int'(addr[1:0]);
            m_raw = raw_of(m_kind, m_lat, m_s2, m_pol);
            if (rd) begin
                m_rd = '0;
                if (s == 0) m_rd = m_pol[g*GW +: GW];
                else if (s == 1) m_rd = m_kind[g*GW +: GW];
                else if (s == 4) m_rd = m_raw[g*GW +: GW];
                else if (s == 5) m_rd = m_mask[g*GW +: GW];
                else if (s == 8) m_rd = m_raw[g*GW +: GW] & m_mask[g*GW +: GW];
                else if (s >= 9 && s < 9 + NO) m_rd = m_om[s-9][g*GW +: GW];
                m_rd_due = 1'b1;
            end
            m_set = '0; m_clr = '0; m_mset = '0; m_mclr = '0;
            if (wr) begin
                if (s == 2) m_clr[g*GW +: GW] = wdata;
                if (s == 3) m_set[g*GW +: GW] = wdata;
                if (s == 6) m_mclr[g*GW +: GW] = wdata;
                if (s == 7) m_mset[g*GW +: GW] = wdata;
            end
            for (int i = 0; i < N; i++) begin
                m_det[i] = m_kind[i] && (m_pol[i] ? (m_s2[i] && !m_prev[i]) : (!m_s2[i] && m_prev[i]));
                if (!m_kind[i]) m_lat[i] = 1'b0;
                else if (m_det[i] || m_set[i]) m_lat[i] = 1'b1;
                else if (m_clr[i]) m_lat[i] = 1'b0;
            end
            if (wr) begin
                if (s == 0) m_pol[g*GW +: GW] = wdata;
                if (s == 1) m_kind[g*GW +: GW] = wdata;
                if (s == 5) m_mask[g*GW +: GW] = wdata;
                if (s >= 9 && s < 9 + NO) m_om[s-9][g*GW +: GW] = wdata;
            end
            m_mask = (m_mask & ~m_mclr) | m_mset;
            m_prev = m_s2; m_s2 = m_s1; m_s1 = pins;
        end
    end

    // R8: outputs and any due read compared at every falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            logic [NO-1:0] e;
            logic [N-1:0]  p;
            p = raw_of(m_kind, m_lat, m_s2, m_pol) & m_mask;
            for (int k = 0; k < NO; k++) e[k] = |(p & m_om[k]);
            n_cmp++;
            if (evt !== e) begin
                n_bad++;
                $display("FAIL R8 cycle %0d outputs act=%b exp=%b", cyc, evt, e);
            end
            if (m_rd_due) begin
                n_cmp++;
                if (rdata !== m_rd) begin
                    n_bad++;
                    $display("FAIL R9 cycle %0d read act=%h exp=%h", cyc, rdata, m_rd);
                end
                m_rd_due = 1'b0;
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 20000) begin
            n_bad++;
            $display("FAIL watchdog act=%0d exp<20000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [GW-1:0] act, input logic [GW-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wreg(input int s, input int g, input logic [GW-1:0] d);
        wr = 1'b1; addr = {s[3:0], g[1:0]}; wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rreg(input int s, input int g, output logic [GW-1:0] d);
        rd = 1'b1; addr = {s[3:0], g[1:0]};
        @(negedge clk);
        rd = 1'b0;
        d = rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        logic [GW-1:0] v;
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R7 reset state
        chk("R7 outputs", {27'd0, evt}, 32'h0);
        rreg(5, 3, v); chk("R7 mask", v, 32'hFFFF_FFFF);
        rreg(0, 0, v); chk("R7 polarity", v, 32'hFFFF_FFFF);
        rreg(1, 2, v); chk("R7 sensitivity", v, 32'h0);
        rreg(10, 1, v); chk("R7 output mask", v, 32'h0);

        // R1 level, both polarities
        pins[3] = 1'b1;
        wreg(0, 0, ~32'h20);
        idle(3);
        rreg(4, 0, v); chk("R1 raw level", v, 32'h28);

        // R2 edge capture persists
        wreg(1, 1, 32'h3);
        idle(3);
        pins[32] = 1'b1; idle(2); pins[32] = 1'b0;
        idle(5);
        rreg(4, 1, v); chk("R2 edge held", v, 32'h1);

        // R3 clear with zeros, then ones
        wreg(2, 1, 32'h0); idle(1);
        rreg(4, 1, v); chk("R3 zero clear", v, 32'h1);
        wreg(2, 1, 32'h1); idle(1);
        rreg(4, 1, v); chk("R3 clear", v, 32'h0);

        // R4 forced set, no effect on level input
        wreg(3, 1, 32'h2); idle(1);
        rreg(4, 1, v); chk("R4 forced", v, 32'h2);
        wreg(3, 0, 32'h80); idle(1);
        rreg(4, 0, v); chk("R4 level ignores set", v, 32'h28);

        // R4 edge and clear in the same cycle: edge wins
        wreg(2, 1, 32'h2); idle(1);
        pins[32] = 1'b1;
        idle(2);
        wreg(2, 1, 32'h1);
        idle(1);
        rreg(4, 1, v); chk("R4 edge beats clear", v, 32'h1);

        // R5 mask aliases and direct write
        wreg(6, 0, 32'h8);
        rreg(5, 0, v); chk("R5 mask clear", v, ~32'h8);
        wreg(6, 0, 32'h0); wreg(7, 0, 32'h0);
        rreg(5, 0, v); chk("R5 zeros no effect", v, ~32'h8);
        // R6 pending with bit3 masked off
        rreg(8, 0, v); chk("R6 pending", v, 32'h20);
        wreg(8, 0, 32'h0);
        rreg(8, 0, v); chk("R6 write ignored", v, 32'h20);
        wreg(7, 0, 32'h8);
        rreg(5, 0, v); chk("R5 mask set", v, 32'hFFFF_FFFF);
        wreg(5, 2, 32'h0F);
        rreg(5, 2, v); chk("R5 direct write", v, 32'h0F);

        // R8 output routing
        wreg(9, 0, 32'h20);
        wreg(10, 1, 32'h2);
        idle(1);
        chk("R8 out0 out1", {27'd0, evt}, 32'h1);
        wreg(3, 1, 32'h2); idle(1);
        chk("R8 out1 on", {27'd0, evt}, 32'h3);
        wreg(6, 0, 32'h20); idle(1);
        chk("R8 out0 masked", {27'd0, evt}, 32'h2);
        wreg(6, 1, 32'hFFFF_FFFF); wreg(6, 0, 32'hFFFF_FFFF);
        wreg(6, 2, 32'hFFFF_FFFF); wreg(6, 3, 32'hFFFF_FFFF);
        idle(1);
        chk("R8 all masked", {27'd0, evt}, 32'h0);

        // R9 write-only and unmapped codes read zero
        rreg(2, 1, v); chk("R9 wo reads zero", v, 32'h0);
        rreg(15, 0, v); chk("R9 unmapped", v, 32'h0);

        // varied pin activity on level and edge groups, model-compared
        wreg(7, 0, 32'hFFFF_FFFF); wreg(7, 1, 32'hFFFF_FFFF);
        wreg(9, 1, 32'hFFFF_FFFF); wreg(11, 0, 32'hFFFF_0000);
        wreg(0, 1, 32'h5555_5555);
        for (int i = 0; i < 60; i++) begin
            pins[63:0] = {pins[62:0], pins[63] ^ pins[40] ^ (i[2:0] == 3'd5)};
            if (i % 11 == 0) wreg(2, 1, 32'hFFFF_FFFF);
            else idle(1);
        end
        idle(4);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule